// File: doc/BRIEF.md
# Trailer Tag Stripper and Forwarding Decoder

This block sits on the byte stream that a host processor sends into one port of a switch. In tagged mode the last byte of every frame is a forwarding tag, not frame data. The block removes that byte from the stream. It moves the end-of-frame marker onto the byte before the tag, and it decodes the tag into a per-frame sideband. The sideband carries a destination port mask, a lookup/direct-forward flag, an egress queue number and an override flag.

In pass-through mode frames go out unchanged, tag byte included. Their sideband asks for normal address lookup. The sideband becomes valid in the same cycle as the frame's last output byte. It stays there until the consumer acknowledges it. Tagged frames that are too short to hold any data are dropped and flagged.

Top module: `tail_tag_strip`

## Requirements
- R1: While reset is asserted, `out_valid`, `sb_valid`, `runt_err` and `sb_overrun` are all 0.
- R2: In tagged mode the final byte of each frame never appears at the output. Every other byte appears in order, one clock after the next input beat of the same frame. `out_sof` is on the first byte and `out_eof` is on the byte that came before the tag. A two-byte frame produces one output byte with both markers set.
- R3: With the mode input at 0, every input beat appears unchanged, markers included, one clock later. The sideband of such a frame is mask 0000, queue 0, lookup 1, override 0.
- R4: In tagged mode, a tag with bit 7 clear and bits [3:0] = 0000 gives lookup 1, mask 0000, override 0 and queue = tag bits [5:4].
- R5: Tag bits [3:0] of 0001, 0010, 0100 and 1000 give lookup 0 and mask bit 0, 1, 2 and 3 respectively. Mask bit n stands for switch port n+1.
- R6: Tag bits [3:0] of 1111 give mask 1111, which is all four ports. Any other nonzero value of bits [3:0] is used as the mask bit for bit. Lookup is 0 in both cases.
- R7: With bit 7 clear, the queue output equals tag bits [5:4]: upper nibble 0000/0001/0010/0011 selects queue 0/1/2/3.
- R8: With bit 7 clear, the override output equals tag bit 6 when bits [3:0] are nonzero. It is 0 when bits [3:0] are 0000.
- R9: A tag with bit 7 set gives lookup 1, mask 0000, queue 0 and override 0, whatever bits [6:0] hold.
- R10: `sb_valid` rises in the cycle that carries the frame's last output byte. The sideband fields hold steady while `sb_valid` is 1 and `sb_ack` is 0. `sb_valid` falls in the cycle after an acknowledge, unless another frame ends in that same cycle.
- R11: A one-byte frame in tagged mode produces no output byte and no sideband. `runt_err` is 1 for exactly the one cycle after that beat.
- R12: If a frame ends while `sb_valid` is 1 and `sb_ack` is 0, the held sideband is kept and the new one is discarded. `sb_overrun` is 1 for that one cycle.
- R13: The mode input is sampled on the start-of-frame beat and governs the whole frame. Changing it in mid-frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tag_en | input | 1 | 1: strip and decode the trailer tag; 0: pass-through |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | Input byte is the first of a frame |
| in_eof | input | 1 | Input byte is the last of a frame |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_sof | output | 1 | Output byte is the first of a frame |
| out_eof | output | 1 | Output byte is the last of a frame |
| out_data | output | 8 | Output byte |
| sb_valid | output | 1 | Sideband holds a decoded frame result |
| sb_mask | output | 4 | Destination port mask, bit n = port n+1 |
| sb_queue | output | 2 | Egress queue number |
| sb_lookup | output | 1 | 1: use address lookup; 0: forward directly to sb_mask |
| sb_override | output | 1 | Forward to sb_mask regardless of other decisions |
| sb_ack | input | 1 | Consumer takes the sideband |
| runt_err | output | 1 | One-cycle pulse: a tagged frame was too short and was dropped |
| sb_overrun | output | 1 | One-cycle pulse: a frame result was lost because the sideband was still unacknowledged |

## Verification
The tag decoder is driven with one tag for each forwarding class:
- a zero destination with each queue value;
- each single-port code;
- the all-ports code and a raw multi-bit mask;
- override tags with zero and nonzero destinations;
- tags with bit 7 set and nonzero low bits, which shows that bit 7 masks everything below it.

The strip path is run with:
- frames fed back to back;
- frames with idle gaps between beats, which shows that the held byte waits for the next beat rather than for the clock;
- minimum-length frames of one and two bytes, which separate the runt drop from the shortest valid frame.

Mode flips in mid-frame, in both directions, show that the mode is latched at start of frame. Withholding the acknowledge across a second frame shows that the held result is kept rather than overwritten.

// File: rtl/tail_tag_strip.sv
module tail_tag_strip (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tag_en,
  input  logic       in_valid,
  input  logic       in_sof,
  input  logic       in_eof,
  input  logic [7:0] in_data,
  output logic       out_valid,
  output logic       out_sof,
  output logic       out_eof,
  output logic [7:0] out_data,
  output logic       sb_valid,
  output logic [3:0] sb_mask,
  output logic [1:0] sb_queue,
  output logic       sb_lookup,
  output logic       sb_override,
  input  logic       sb_ack,
  output logic       runt_err,
  output logic       sb_overrun
);
  localparam int PORTS = 4;
  localparam int QW    = 2;

  logic             frm_tag, mode;
  logic             hold_vld, hold_sof;
  logic [7:0]       hold_data;
  logic [PORTS-1:0] d_mask;
  logic [QW-1:0]    d_queue;
  logic             d_lookup, d_override;
  logic             res_vld, sb_free;

  assign mode    = in_sof ? tag_en : frm_tag;
  assign res_vld = in_valid && in_eof && !(mode && in_sof);
  assign sb_free = !sb_valid || sb_ack;

  always_comb begin
    d_mask     = '0;
    d_queue    = '0;
    d_lookup   = 1'b1;
    d_override = 1'b0;
    if (mode && !in_data[7]) begin
      d_queue = in_data[4 +: QW];
      if (in_data[PORTS-1:0] != '0) begin
        d_mask     = in_data[PORTS-1:0];
        d_lookup   = 1'b0;
        d_override = in_data[6];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_tag   <= 1'b0;
      hold_vld  <= 1'b0;
      hold_sof  <= 1'b0;
      hold_data <= '0;
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      out_data  <= '0;
      runt_err  <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      runt_err  <= 1'b0;
      if (in_valid) begin
        if (in_sof) frm_tag <= tag_en;
        if (!mode) begin
          out_valid <= 1'b1;
          out_sof   <= in_sof;
          out_eof   <= in_eof;
          out_data  <= in_data;
          hold_vld  <= 1'b0;
        end else begin
          if (hold_vld && !in_sof) begin
            out_valid <= 1'b1;
            out_sof   <= hold_sof;
            out_eof   <= in_eof;
            out_data  <= hold_data;
          end
          if (in_sof && in_eof) runt_err <= 1'b1;
          hold_data <= in_data;
          hold_sof  <= in_sof;
          hold_vld  <= !in_eof;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sb_valid    <= 1'b0;
      sb_mask     <= '0;
      sb_queue    <= '0;
      sb_lookup   <= 1'b0;
      sb_override <= 1'b0;
      sb_overrun  <= 1'b0;
    end else begin
      sb_overrun <= 1'b0;
      if (res_vld && sb_free) begin
        sb_valid    <= 1'b1;
        sb_mask     <= d_mask;
        sb_queue    <= d_queue;
        sb_lookup   <= d_lookup;
        sb_override <= d_override;
      end else begin
        if (res_vld) sb_overrun <= 1'b1;
        if (sb_ack)  sb_valid   <= 1'b0;
      end
    end
  end
endmodule

module tail_tag_strip_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       out_valid,
  input logic       out_eof,
  input logic       sb_valid,
  input logic [3:0] sb_mask,
  input logic [1:0] sb_queue,
  input logic       sb_lookup,
  input logic       sb_override,
  input logic       sb_ack,
  input logic       runt_err,
  input logic       sb_overrun
);
  // R10
  sb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sb_valid && !sb_ack |=> sb_valid && $stable(sb_mask) && $stable(sb_queue)
                            && $stable(sb_lookup) && $stable(sb_override));
  // R10
  sb_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sb_valid) |-> out_valid && out_eof);
  // R9
  lookup_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sb_valid && sb_lookup |-> sb_mask == 4'b0000 && !sb_override);
  // R8
  override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sb_valid && sb_override |-> sb_mask != 4'b0000);
  // R11
  runt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    runt_err |-> !out_valid);
  // R12
  overrun_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sb_overrun |-> sb_valid && $stable(sb_mask) && $stable(sb_queue));
endmodule

bind tail_tag_strip tail_tag_strip_chk u_chk (.*);

// File: tb/tail_tag_strip_test.sv
module tail_tag_strip_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, tag_en, in_valid, in_sof, in_eof, sb_ack;
  logic [7:0] in_data;
  logic out_valid, out_sof, out_eof, sb_valid, sb_lookup, sb_override, runt_err, sb_overrun;
  logic [7:0] out_data;
  logic [3:0] sb_mask;
  logic [1:0] sb_queue;

  tail_tag_strip uut (.*);

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void ref_decode(input logic [7:0] t, output logic [3:0] m,
                                     output logic [1:0] q, output logic l, output logic o);
    int v = int'(t);
    m = 4'd0; q = 2'd0; l = 1'b1; o = 1'b0;
    if (v < 128) begin
      q = 2'((v / 16) % 4);
      if (v % 16 != 0) begin
        m = 4'(v % 16);
        l = 1'b0;
        o = 1'((v / 64) % 2);
      end
    end
  endfunction

  logic e_ov, e_sof, e_eof, e_runt, e_orun, e_sbv, e_lk, e_ovr;
  logic [7:0] e_d;
  logic [3:0] e_mask;
  logic [1:0] e_q;
  bit m_tag, m_first;
  logic [7:0] pend[$];

  always @(posedge clk) begin
    logic [3:0] nm;
    logic [1:0] nq;
    logic nl, no;
    if (!rst_n) begin
      e_ov = 0; e_sof = 0; e_eof = 0; e_runt = 0; e_orun = 0; e_sbv = 0;
      e_d = 0; e_mask = 0; e_q = 0; e_lk = 0; e_ovr = 0;
      m_tag = 0; m_first = 0; pend.delete();
    end else begin
      e_ov = 0; e_sof = 0; e_eof = 0; e_runt = 0; e_orun = 0;
      if (in_valid) begin
        if (in_sof) m_tag = tag_en;
        if (!m_tag) begin
          e_ov = 1; e_d = in_data; e_sof = in_sof; e_eof = in_eof;
          pend.delete();
        end else begin
          if (in_sof) begin pend.delete(); m_first = 1; end
          else if (pend.size() > 0) begin
            e_ov = 1; e_d = pend.pop_front(); e_sof = m_first; e_eof = in_eof;
            m_first = 0;
          end
          if (in_eof) begin
            if (in_sof) e_runt = 1;
            pend.delete();
          end else pend.push_back(in_data);
        end
      end
      if (in_valid && in_eof && !(m_tag && in_sof)) begin
        if (m_tag) ref_decode(in_data, nm, nq, nl, no);
        else begin nm = 0; nq = 0; nl = 1; no = 0; end
        if (!e_sbv || sb_ack) begin
          e_sbv = 1; e_mask = nm; e_q = nq; e_lk = nl; e_ovr = no;
        end else e_orun = 1;
      end else if (sb_ack) e_sbv = 0;
    end
  end

  always @(negedge clk) begin
    string rq;
    if (rst_n && !done) begin
      rq = m_tag ? "R2" : "R3";
      chk(out_valid === e_ov, rq, "out_valid", int'(out_valid), int'(e_ov));
      if (e_ov) begin
        chk(out_data === e_d, rq, "out_data", int'(out_data), int'(e_d));
        chk(out_sof === e_sof, rq, "out_sof", int'(out_sof), int'(e_sof));
        chk(out_eof === e_eof, rq, "out_eof", int'(out_eof), int'(e_eof));
      end
      chk(sb_valid === e_sbv, "R10", "sb_valid", int'(sb_valid), int'(e_sbv));
      if (e_sbv) begin
        chk(sb_mask === e_mask, "R10", "sb_mask", int'(sb_mask), int'(e_mask));
        chk(sb_queue === e_q, "R10", "sb_queue", int'(sb_queue), int'(e_q));
        chk(sb_lookup === e_lk, "R10", "sb_lookup", int'(sb_lookup), int'(e_lk));
        chk(sb_override === e_ovr, "R10", "sb_override", int'(sb_override), int'(e_ovr));
      end
      chk(runt_err === e_runt, "R11", "runt_err", int'(runt_err), int'(e_runt));
      chk(sb_overrun === e_orun, "R12", "sb_overrun", int'(sb_overrun), int'(e_orun));
    end
  end

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 0; in_sof = 0; in_eof = 0;
    end
  endtask

  task automatic frame(int n, logic [7:0] tag, int gap, bit flip);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (flip && i == 1) tag_en = ~tag_en;
      in_valid = 1; in_sof = (i == 0); in_eof = (i == n - 1);
      in_data = (i == n - 1) ? tag : 8'(8'h30 + i * 7);
      if (gap > 0 && i < n - 1) idle(gap);
    end
    idle(1);
  endtask

  task automatic expect_sb(logic [3:0] m, logic [1:0] q, logic l, logic o, string req);
    chk(sb_valid === 1'b1, req, "sb_valid", int'(sb_valid), 1);
    chk(sb_mask === m, req, "sb_mask", int'(sb_mask), int'(m));
    chk(sb_queue === q, req, "sb_queue", int'(sb_queue), int'(q));
    chk(sb_lookup === l, req, "sb_lookup", int'(sb_lookup), int'(l));
    chk(sb_override === o, req, "sb_override", int'(sb_override), int'(o));
    sb_ack = 1;
    @(negedge clk);
    sb_ack = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    rst_n = 0; tag_en = 1; in_valid = 0; in_sof = 0; in_eof = 0; in_data = 0; sb_ack = 0;
    repeat (3) @(negedge clk);
    // R1
    chk(out_valid === 1'b0, "R1", "out_valid", int'(out_valid), 0);
    chk(sb_valid === 1'b0, "R1", "sb_valid", int'(sb_valid), 0);
    chk(runt_err === 1'b0, "R1", "runt_err", int'(runt_err), 0);
    chk(sb_overrun === 1'b0, "R1", "sb_overrun", int'(sb_overrun), 0);
    rst_n = 1;
    idle(2);

    frame(5, 8'h00, 0, 0); expect_sb(4'h0, 2'd0, 1, 0, "R4");
    frame(4, 8'h30, 0, 0); expect_sb(4'h0, 2'd3, 1, 0, "R4");
    frame(4, 8'h01, 0, 0); expect_sb(4'h1, 2'd0, 0, 0, "R5");
    frame(4, 8'h12, 1, 0); expect_sb(4'h2, 2'd1, 0, 0, "R5");
    frame(4, 8'h24, 0, 0); expect_sb(4'h4, 2'd2, 0, 0, "R7");
    frame(6, 8'h38, 2, 0); expect_sb(4'h8, 2'd3, 0, 0, "R7");
    frame(3, 8'h0F, 0, 0); expect_sb(4'hF, 2'd0, 0, 0, "R6");
    frame(3, 8'h05, 0, 0); expect_sb(4'h5, 2'd0, 0, 0, "R6");
    frame(5, 8'h42, 2, 0); expect_sb(4'h2, 2'd0, 0, 1, "R8");
    frame(3, 8'h70, 0, 0); expect_sb(4'h0, 2'd3, 1, 0, "R8");
    frame(3, 8'h8F, 0, 0); expect_sb(4'h0, 2'd0, 1, 0, "R9");
    frame(3, 8'hFF, 1, 0); expect_sb(4'h0, 2'd0, 1, 0, "R9");

    tag_en = 0;
    frame(3, 8'h4F, 0, 0); expect_sb(4'h0, 2'd0, 1, 0, "R3");
    frame(1, 8'h21, 0, 0); expect_sb(4'h0, 2'd0, 1, 0, "R3");

    tag_en = 1;
    frame(4, 8'h21, 0, 1); expect_sb(4'h1, 2'd2, 0, 0, "R13");
    frame(4, 8'h21, 1, 1); expect_sb(4'h0, 2'd0, 1, 0, "R13");

    frame(1, 8'h04, 0, 0);
    chk(runt_err === 1'b1, "R11", "runt_err", int'(runt_err), 1);
    chk(sb_valid === 1'b0, "R11", "sb_valid", int'(sb_valid), 0);
    frame(2, 8'h08, 0, 0); expect_sb(4'h8, 2'd0, 0, 0, "R2");

    frame(3, 8'h01, 0, 0);
    idle(3);
    frame(3, 8'h02, 0, 0);
    expect_sb(4'h1, 2'd0, 0, 0, "R12");
    chk(sb_valid === 1'b0, "R10", "sb_valid after ack", int'(sb_valid), 0);

    frame(3, 8'h14, 0, 0);
    sb_ack = 1;
    frame(3, 8'h28, 0, 0);
    sb_ack = 0;
    expect_sb(4'h8, 2'd2, 0, 0, "R10");

    idle(4);
    finish_run();
  end
endmodule